// File: doc/BRIEF.md
# Branch Clock Gate with Observed Status

This block sits between a root clock and one consumer. It passes the root clock on to the consumer or holds it low, and it can thin the pulse train by a small post-divide count. Software drives the block through a 32-bit control register on a bus clock. An enable bit asks for the clock. A separate status field reports what the gate has actually done, once the request has crossed into the root domain and the gate has switched. Software therefore writes the request and then polls the status field until it shows the state it wants.

When hardware gating is selected, an external request input can also open the gate. The status then carries a distinct code that means "running under hardware control". The control register also holds two retention requests, one for memory state and one for peripheral state, which go straight to outputs. A second register at address 1 holds the consumer's block reset.

The gate changes only while the root clock is low, so no pulse is ever cut short. If the root clock stops, the status stops claiming that the clock is running.

Top module: `branch_gate`

## Requirements
- R1: After reset, the control register (address 0) reads 0x8000_0000: status off and every control field zero. The block-reset register (address 1) reads 0, and `blk_rst`, `retain_periph` and `retain_mem` are low.
- R2: Writing 1 to control bit 0 opens the gate. Once the change has settled, status bits [31:28] read 0x0 and every root pulse appears on `branch_clk`.
- R3: Clearing bit 0, with hardware gating not selected, closes the gate. Status reads 0x8 and `branch_clk` stays low.
- R4: When control bit 1 is set, the gate is open whenever `hw_req` or bit 0 is high, and status reads 0x2 while it is open. With bit 1 set and both `hw_req` and bit 0 low, status reads 0x8 and no pulses pass.
- R5: The post-divide value D in control bits [24:16] lets exactly one root pulse through in every D+1 consecutive root pulses, and it reads back in the same bits.
- R6: Control bit 13 drives `retain_periph` and bit 14 drives `retain_mem`. Both read back.
- R7: Bit 0 of the register at address 1 drives `blk_rst`: 1 asserts it and 0 releases it. The bit reads back.
- R8: Control bits 2..12, 15 and 25..27, and bits 1..31 of address 1, read as 0 whatever is written to them.
- R9: If no root clock edge arrives for STALL_CYCLES bus cycles, status reads 0x8. Normal reporting resumes once the root clock runs again.
- R10: The status field only ever holds 0x0, 0x2 or 0x8.
- R11: In the bus cycle right after a write to the enable bit, the status field still shows the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register (bus) clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| root_clk | input | 1 | Root clock to be gated |
| hw_req | input | 1 | Hardware gate request, used when hardware gating is selected |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the control register, 1 selects the block-reset register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| branch_clk | output | 1 | Gated and divided clock to the consumer |
| blk_rst | output | 1 | Consumer block reset |
| retain_periph | output | 1 | Peripheral state retention request |
| retain_mem | output | 1 | Memory state retention request |

## Verification
The assertions assume that the divide field and the hardware-gating select bit change only while the gate is closed. They also assume that `root_clk` is free of glitches and stops in its low phase. The stimulus follows these rules: it closes the gate and waits for status 0x8 before it writes a new divide value or selects hardware gating, and the root clock generator always parks low. Pulse counts are taken over windows that span a whole multiple of D+1 root pulses, so the expected count does not depend on where the divider phase stands when the window starts.

// File: rtl/bgate_pkg.sv
package bgate_pkg;
  localparam int REG_W     = 32;
  localparam int EN_BIT    = 0;
  localparam int HW_BIT    = 1;
  localparam int RET_P_BIT = 13;
  localparam int RET_M_BIT = 14;
  localparam int DIV_LSB   = 16;
  localparam int DIV_MSB   = 24;
  localparam int ST_LSB    = 28;
  localparam int ST_W      = 4;

  typedef enum logic [ST_W-1:0] {
    ST_ON   = 4'h0,
    ST_HWON = 4'h2,
    ST_OFF  = 4'h8
  } gate_status_e;

  typedef struct packed {
    logic open;
    logic hw;
  } gate_obs_t;
endpackage

// File: rtl/bgate_regs.sv
module bgate_regs
  import bgate_pkg::*;
#(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             hw_req,
  input  gate_status_e     status,
  output logic [REG_W-1:0] rdata,
  output logic             eff_req,
  output logic             hw_ctl,
  output logic [DIV_W-1:0] div,
  output logic             ret_p,
  output logic             ret_m,
  output logic             blk_rst
);
  localparam logic ADDR_CTL = 1'b0;
  localparam logic ADDR_RST = 1'b1;

  logic             en_q, en_d;
  logic             hw_q, hw_d;
  logic             rp_q, rp_d;
  logic             rm_q, rm_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             rst_q, rst_d;
  logic             req_q, req_d;
  logic             ctl_we, rst_we;

  assign ctl_we = wr && (addr == ADDR_CTL);
  assign rst_we = wr && (addr == ADDR_RST);

  always_comb begin
    en_d  = en_q;
    hw_d  = hw_q;
    rp_d  = rp_q;
    rm_d  = rm_q;
    div_d = div_q;
    rst_d = rst_q;
    if (ctl_we) begin
      en_d  = wdata[EN_BIT];
      hw_d  = wdata[HW_BIT];
      rp_d  = wdata[RET_P_BIT];
      rm_d  = wdata[RET_M_BIT];
      div_d = wdata[DIV_LSB +: DIV_W];
    end
    if (rst_we) rst_d = wdata[0];
    req_d = en_q | (hw_q & hw_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      hw_q  <= 1'b0;
      rp_q  <= 1'b0;
      rm_q  <= 1'b0;
      div_q <= '0;
      rst_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      hw_q  <= hw_d;
      rp_q  <= rp_d;
      rm_q  <= rm_d;
      div_q <= div_d;
      rst_q <= rst_d;
      req_q <= req_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_RST) begin
      rdata[0] = rst_q;
    end else begin
      rdata[EN_BIT]              = en_q;
      rdata[HW_BIT]              = hw_q;
      rdata[RET_P_BIT]           = rp_q;
      rdata[RET_M_BIT]           = rm_q;
      rdata[DIV_LSB +: DIV_W]    = div_q;
      rdata[ST_LSB +: ST_W]      = status;
    end
  end

  assign eff_req = req_q;
  assign hw_ctl  = hw_q;
  assign div     = div_q;
  assign ret_p   = rp_q;
  assign ret_m   = rm_q;
  assign blk_rst = rst_q;

  assert_blk_rst_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_we |=> (blk_rst == $past(wdata[0])));

  assert_status_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_ON) || (status == ST_HWON) || (status == ST_OFF));

  assert_retain_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ret_m == $past(wdata[RET_M_BIT])) && (ret_p == $past(wdata[RET_P_BIT])));
endmodule

// File: rtl/bgate_root.sv
module bgate_root
  import bgate_pkg::*;
#(
  parameter int DIV_W = 9
) (
  input  logic             root_clk,
  input  logic             rst_n,
  input  logic             req_async,
  input  logic             hw_async,
  input  logic [DIV_W-1:0] div,
  output logic             branch_clk,
  output gate_obs_t        obs,
  output logic             tog
);
  logic             rr1_q, rr2_q;
  logic             rq1_q, rq2_q;
  logic             hq1_q, hq2_q;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  gate_obs_t        p1_q, obs_q;
  logic             tog_q;
  logic             lat_en;
  logic             pass_d;

  always_ff @(posedge root_clk or negedge rst_n) begin
    if (!rst_n) begin
      rr1_q <= 1'b0;
      rr2_q <= 1'b0;
    end else begin
      rr1_q <= 1'b1;
      rr2_q <= rr1_q;
    end
  end

  always_comb begin
    if (!rq2_q)              cnt_d = '0;
    else if (cnt_q >= div)   cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
    pass_d = rq2_q && (cnt_q == '0);
  end

  always_ff @(posedge root_clk or negedge rr2_q) begin
    if (!rr2_q) begin
      rq1_q <= 1'b0;
      rq2_q <= 1'b0;
      hq1_q <= 1'b0;
      hq2_q <= 1'b0;
      cnt_q <= '0;
      p1_q  <= '0;
      obs_q <= '0;
      tog_q <= 1'b0;
    end else begin
      rq1_q <= req_async;
      rq2_q <= rq1_q;
      hq1_q <= hw_async;
      hq2_q <= hq1_q;
      cnt_q <= cnt_d;
      p1_q  <= '{open: rq2_q, hw: hq2_q};
      obs_q <= p1_q;
      tog_q <= ~tog_q;
    end
  end

  always_latch begin
    if (!rr2_q)         lat_en = 1'b0;
    else if (!root_clk) lat_en = pass_d;
  end

  assign branch_clk = root_clk & lat_en;
  assign obs        = obs_q;
  assign tog        = tog_q;

  assert_div_step_R5: assert property (@(posedge root_clk) disable iff (!rr2_q)
    (cnt_q != '0) |-> (cnt_q == $past(cnt_q) + 1'b1));

  assert_closed_count_R3: assert property (@(posedge root_clk) disable iff (!rr2_q)
    !$past(rq2_q) |-> (cnt_q == '0));
endmodule

// File: rtl/bgate_stat.sv
module bgate_stat
  import bgate_pkg::*;
#(
  parameter int STALL_CYCLES = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  gate_obs_t    obs_async,
  input  logic         tog_async,
  output gate_status_e status
);
  localparam int CNT_W = $clog2(STALL_CYCLES + 1);
  localparam logic [CNT_W-1:0] STALL_LIM = CNT_W'(STALL_CYCLES);

  gate_obs_t        s1_q, s2_q, s3_q, held_q, held_d;
  logic             t1_q, t2_q, t3_q;
  logic [CNT_W-1:0] idle_q, idle_d;
  logic             stalled;

  always_comb begin
    held_d = held_q;
    if (s2_q == s3_q) held_d = s2_q;
    if (t2_q != t3_q)          idle_d = '0;
    else if (idle_q == STALL_LIM) idle_d = idle_q;
    else                       idle_d = idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      s3_q   <= '0;
      held_q <= '0;
      t1_q   <= 1'b0;
      t2_q   <= 1'b0;
      t3_q   <= 1'b0;
      idle_q <= '0;
    end else begin
      s1_q   <= obs_async;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      held_q <= held_d;
      t1_q   <= tog_async;
      t2_q   <= t1_q;
      t3_q   <= t2_q;
      idle_q <= idle_d;
    end
  end

  assign stalled = (idle_q == STALL_LIM);

  always_comb begin
    if (stalled || !held_q.open) status = ST_OFF;
    else if (held_q.hw)          status = ST_HWON;
    else                         status = ST_ON;
  end

  assert_stall_not_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> (status == ST_OFF));
endmodule

// File: rtl/branch_gate.sv
module branch_gate
  import bgate_pkg::*;
#(
  parameter int DIV_W        = 9,
  parameter int STALL_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        root_clk,
  input  logic        hw_req,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        branch_clk,
  output logic        blk_rst,
  output logic        retain_periph,
  output logic        retain_mem
);
  localparam int DIV_FIELD_W = DIV_MSB - DIV_LSB + 1;

  logic             eff_req, hw_ctl;
  logic [DIV_W-1:0] div;
  gate_obs_t        obs;
  logic             tog;
  gate_status_e     status;

  initial begin
    if (DIV_W > DIV_FIELD_W || DIV_W < 1)
      $error("DIV_W out of range for the divide field");
  end

  bgate_regs #(.DIV_W(DIV_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .hw_req  (hw_req),
    .status  (status),
    .rdata   (reg_rdata),
    .eff_req (eff_req),
    .hw_ctl  (hw_ctl),
    .div     (div),
    .ret_p   (retain_periph),
    .ret_m   (retain_mem),
    .blk_rst (blk_rst)
  );

  bgate_root #(.DIV_W(DIV_W)) u_root (
    .root_clk   (root_clk),
    .rst_n      (rst_n),
    .req_async  (eff_req),
    .hw_async   (hw_ctl),
    .div        (div),
    .branch_clk (branch_clk),
    .obs        (obs),
    .tog        (tog)
  );

  bgate_stat #(.STALL_CYCLES(STALL_CYCLES)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .obs_async (obs),
    .tog_async (tog),
    .status    (status)
  );
endmodule

// File: tb/branch_gate_bench.sv
module branch_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROOT_HALF  = 7;
  localparam int SETTLE     = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        root_clk = 1'b0;
  logic        root_run = 1'b1;
  logic        hw_req = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        branch_clk, blk_rst, retain_periph, retain_mem;

  int vectors = 0;
  int misses  = 0;

  branch_gate u_branch_gate (
    .clk(clk), .rst_n(rst_n), .root_clk(root_clk), .hw_req(hw_req),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .branch_clk(branch_clk), .blk_rst(blk_rst),
    .retain_periph(retain_periph), .retain_mem(retain_mem)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    #(ROOT_HALF);
    if (root_run) root_clk = ~root_clk;
    else          root_clk = 1'b0;
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic count_pulses(input int m, output int n);
    n = 0;
    for (int i = 0; i < m; i++) begin
      @(posedge root_clk);
      #1 if (branch_clk) n++;
    end
  endtask

  function automatic logic [31:0] stat_of(input logic [31:0] v);
    return {28'h0, v[31:28]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    rd(1'b0, v); check(v, 32'h8000_0000, "R1 ctl reset");
    rd(1'b1, v); check(v, 32'h0, "R1 blk reset reg");
    check({29'h0, blk_rst, retain_periph, retain_mem}, 32'h0, "R1 outputs");

    // R11: status unchanged the cycle after the write
    wr(1'b0, 32'h1);
    #1 check(stat_of(reg_rdata), 32'h8, "R11 pending status");
    settle();
    rd(1'b0, v); check(stat_of(v), 32'h0, "R2 status on");
    count_pulses(10, n); check(n, 10, "R2 all pulses");

    wr(1'b0, 32'h0); settle();
    rd(1'b0, v); check(stat_of(v), 32'h8, "R3 status off");
    count_pulses(12, n); check(n, 0, "R3 no pulses");

    // R5 sweep of divide values, windows of whole periods
    for (int d = 0; d < 8; d++) begin
      wr(1'b0, 32'(d) << 16); settle();
      wr(1'b0, (32'(d) << 16) | 32'h1); settle();
      rd(1'b0, v); check((v >> 16) & 32'h1FF, 32'(d), "R5 divide readback");
      count_pulses((d + 1) * 6, n); check(n, 6, "R5 divided pulse count");
      wr(1'b0, 32'(d) << 16); settle();
    end
    wr(1'b0, 32'h0); settle();

    // R4 hardware gating
    wr(1'b0, 32'h2); settle();
    rd(1'b0, v); check(stat_of(v), 32'h8, "R4 hw idle off");
    count_pulses(8, n); check(n, 0, "R4 hw idle no pulses");
    hw_req = 1'b1; settle();
    rd(1'b0, v); check(stat_of(v), 32'h2, "R4 hw on status");
    count_pulses(8, n); check(n, 8, "R4 hw pulses");
    hw_req = 1'b0; settle();
    rd(1'b0, v); check(stat_of(v), 32'h8, "R4 hw release off");
    wr(1'b0, 32'h3); settle();
    rd(1'b0, v); check(stat_of(v), 32'h2, "R4 sw under hw select");
    wr(1'b0, 32'h0); settle();

    // R6 retention
    wr(1'b0, 32'h0000_6000);
    check({30'h0, retain_mem, retain_periph}, 32'h3, "R6 both retain");
    rd(1'b0, v); check(v & 32'h0000_6000, 32'h0000_6000, "R6 readback");
    wr(1'b0, 32'h0000_2000);
    check({30'h0, retain_mem, retain_periph}, 32'h1, "R6 periph only");
    wr(1'b0, 32'h0);

    // R7 block reset
    wr(1'b1, 32'h1);
    check({31'h0, blk_rst}, 32'h1, "R7 assert");
    rd(1'b1, v); check(v, 32'h1, "R7 readback");
    wr(1'b1, 32'h0);
    check({31'h0, blk_rst}, 32'h0, "R7 release");

    // R8 unused bits
    wr(1'b1, 32'hFFFF_FFFE);
    rd(1'b1, v); check(v, 32'h0, "R8 reset reg unused");
    check({31'h0, blk_rst}, 32'h0, "R8 blk_rst untouched");
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, v); check(v & 32'h0FFF_FFFF, 32'h01FF_6003, "R8 ctl unused");
    wr(1'b0, 32'h0); settle();

    // R9 stalled root clock
    wr(1'b0, 32'h1); settle();
    rd(1'b0, v); check(stat_of(v), 32'h0, "R9 running before stall");
    root_run = 1'b0; settle();
    rd(1'b0, v); check(stat_of(v), 32'h8, "R9 stalled reports off");
    check({31'h0, branch_clk}, 32'h0, "R9 no clock while stalled");
    root_run = 1'b1; settle();
    rd(1'b0, v); check(stat_of(v), 32'h0, "R9 resumes on");
    wr(1'b0, 32'h0); settle();
    rd(1'b0, v); check(stat_of(v), 32'h8, "R10 final off code");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule